// File: doc/BRIEF.md
# Condition Code Flag Generator

This unit is purely combinational. It produces the updated condition code byte of a small processor once an arithmetic or data-movement step has finished. The datapath passes it four things: the kind of step that ran, a width select (byte or word), the two operands and the result. It also passes the current condition code byte and, for shifts, the bit that the shifter pushed out. The unit then rewrites the negative, zero, overflow and carry flags according to the class of step. Every bit that the step does not affect is copied through.

Carry and overflow are not taken from an adder's carry chain. They come from majority-style expressions on the sign bits of the operands and of the result. The block can therefore sit after any result source, such as an adder, a shifter or a load path. It needs only the three sign bits and a zero detect over the active width.

Top module: `ccr_flag_gen`

## Requirements
- R1: The condition code byte holds the flags in this order, from bit 7 down to bit 0: stop-disable, extended-interrupt mask, half carry, interrupt mask, N, Z, V, C. Bits 7 to 4 of `ccr_o` always equal the same bits of `ccr_i`.
- R2: `op_i` is encoded as 0 = no update, 1 = add, 2 = subtract, 3 = shift, 4 = test/load. For codes 0, 5, 6 and 7, `ccr_o` equals `ccr_i`.
- R3: With `wide_i` = 0, only bits 7:0 of `a_i`, `b_i` and `r_i` are used, and bit 7 is the sign. Bits 15:8 have no effect on the output. With `wide_i` = 1, all 16 bits are used and bit 15 is the sign.
- R4: For codes 1 to 4, N equals the sign bit of the result, and Z is 1 exactly when the result is zero over the active width.
- R5: For add, C is 1 when at least two of these three are 1: sign of a, sign of b, inverted sign of r.
- R6: For add, V is 1 when a and b have the same sign and the sign of r differs from it.
- R7: For subtract, C (borrow) is 1 when at least two of these three are 1: inverted sign of a, sign of b, sign of r.
- R8: For subtract, V is 1 when a and b have different signs and the sign of r differs from the sign of a.
- R9: For shift, C takes the value of `shift_c_i`, and V equals the new N XOR `shift_c_i`.
- R10: For test/load, V is cleared and C keeps its value from `ccr_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Class of the finished step (encoding in R2) |
| wide_i | input | 1 | 0 = byte width, 1 = word width |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| r_i | input | 16 | Result of the step |
| shift_c_i | input | 1 | Bit shifted out by the shifter |
| ccr_i | input | 8 | Current condition code byte |
| ccr_o | output | 8 | Updated condition code byte |

## Verification
The unit holds no state, so any fault appears on `ccr_o` in the same evaluation as the input that exposes it. The most likely faults are a wrong update mask, which leaks or freezes a flag, and a wrong sign-bit tap when the width changes. Both show up as a single wrong bit. The bench therefore compares the whole byte on every vector and pays extra attention to byte mode, with junk placed in the upper operand bits. It also drives results that are not the true sum or difference, so the flag expressions are tested beyond ordinary adder behaviour.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ADD   = 3'd1,
    OP_SUB   = 3'd2,
    OP_SHIFT = 3'd3,
    OP_TEST  = 3'd4
  } ccr_op_e;

  localparam int CCR_W = 8;
  localparam int BIT_N = 3;
  localparam int BIT_Z = 2;
  localparam int BIT_V = 1;
  localparam int BIT_C = 0;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (y & z) | (x & z);
  endfunction

  function automatic logic add_carry(input logic sa, input logic sb, input logic sr);
    return maj3(sa, sb, ~sr);
  endfunction

  function automatic logic add_ovf(input logic sa, input logic sb, input logic sr);
    return (sa & sb & ~sr) | (~sa & ~sb & sr);
  endfunction

  function automatic logic sub_borrow(input logic sa, input logic sb, input logic sr);
    return maj3(~sa, sb, sr);
  endfunction

  function automatic logic sub_ovf(input logic sa, input logic sb, input logic sr);
    return (sa & ~sb & ~sr) | (~sa & sb & sr);
  endfunction
endpackage

// File: rtl/ccr_operand_sel.sv
module ccr_operand_sel #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              wide_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] r_i,
  output logic              sa_o,
  output logic              sb_o,
  output logic              sr_o,
  output logic              rzero_o
);
  localparam int WMSB = DATA_W - 1;
  localparam int NMSB = NARROW_W - 1;

  logic narrow_zero;
  logic wide_zero;

  assign narrow_zero = ~|r_i[NMSB:0];
  assign wide_zero   = ~|r_i;

  always_comb begin
    if (wide_i) begin
      sa_o    = a_i[WMSB];
      sb_o    = b_i[WMSB];
      sr_o    = r_i[WMSB];
      rzero_o = wide_zero;
    end else begin
      sa_o    = a_i[NMSB];
      sb_o    = b_i[NMSB];
      sr_o    = r_i[NMSB];
      rzero_o = narrow_zero;
    end
  end
endmodule

// File: rtl/ccr_arith_flags.sv
module ccr_arith_flags
  import ccr_pkg::*;
(
  input  logic sa_i,
  input  logic sb_i,
  input  logic sr_i,
  output logic add_c_o,
  output logic add_v_o,
  output logic sub_c_o,
  output logic sub_v_o
);
  assign add_c_o = add_carry(sa_i, sb_i, sr_i);
  assign add_v_o = add_ovf(sa_i, sb_i, sr_i);
  assign sub_c_o = sub_borrow(sa_i, sb_i, sr_i);
  assign sub_v_o = sub_ovf(sa_i, sb_i, sr_i);
endmodule

// File: rtl/ccr_flag_merge.sv
module ccr_flag_merge
  import ccr_pkg::*;
(
  input  logic [CCR_W-1:0] ccr_i,
  input  logic [3:0]       upd_i,
  input  logic [3:0]       val_i,
  output logic [CCR_W-1:0] ccr_o
);
  // upd_i/val_i ordering: [3]=N [2]=Z [1]=V [0]=C, matching low nibble
  logic [CCR_W-1:0] mask;
  logic [CCR_W-1:0] setv;

  assign mask = {{(CCR_W-4){1'b0}}, upd_i};
  assign setv = {{(CCR_W-4){1'b0}}, upd_i & val_i};
  assign ccr_o = (ccr_i & ~mask) | setv;
endmodule

// File: rtl/ccr_flag_gen.sv
module ccr_flag_gen
  import ccr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [2:0]        op_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] r_i,
  input  logic              shift_c_i,
  input  logic [CCR_W-1:0]  ccr_i,
  output logic [CCR_W-1:0]  ccr_o
);
  logic sa, sb, sr, rzero;
  logic add_c, add_v, sub_c, sub_v;
  logic upd_n, upd_z, upd_v, upd_c;
  logic new_n, new_z, new_v, new_c;

  ccr_operand_sel #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) sel_i (
    .wide_i(wide_i), .a_i(a_i), .b_i(b_i), .r_i(r_i),
    .sa_o(sa), .sb_o(sb), .sr_o(sr), .rzero_o(rzero)
  );

  ccr_arith_flags arith_i (
    .sa_i(sa), .sb_i(sb), .sr_i(sr),
    .add_c_o(add_c), .add_v_o(add_v), .sub_c_o(sub_c), .sub_v_o(sub_v)
  );

  always_comb begin
    upd_n = 1'b0; upd_z = 1'b0; upd_v = 1'b0; upd_c = 1'b0;
    new_n = sr;   new_z = rzero; new_v = 1'b0; new_c = 1'b0;
    case (op_i)
      OP_ADD: begin
        {upd_n, upd_z, upd_v, upd_c} = 4'b1111;
        new_v = add_v; new_c = add_c;
      end
      OP_SUB: begin
        {upd_n, upd_z, upd_v, upd_c} = 4'b1111;
        new_v = sub_v; new_c = sub_c;
      end
      OP_SHIFT: begin
        {upd_n, upd_z, upd_v, upd_c} = 4'b1111;
        new_c = shift_c_i;
        new_v = sr ^ shift_c_i;
      end
      OP_TEST: begin
        {upd_n, upd_z, upd_v, upd_c} = 4'b1110;
        new_v = 1'b0;
      end
      default: ;
    endcase
  end

  ccr_flag_merge merge_i (
    .ccr_i(ccr_i),
    .upd_i({upd_n, upd_z, upd_v, upd_c}),
    .val_i({new_n, new_z, new_v, new_c}),
    .ccr_o(ccr_o)
  );
endmodule

// File: rtl/ccr_flag_gen_chk.sv
module ccr_flag_gen_chk #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input logic [2:0]        op_i,
  input logic              wide_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [DATA_W-1:0] r_i,
  input logic              shift_c_i,
  input logic [7:0]        ccr_i,
  input logic [7:0]        ccr_o
);
  localparam logic [DATA_W-1:0] NMASK = DATA_W'((1 << NARROW_W) - 1);

  logic [DATA_W:0]   wsum;
  logic [NARROW_W:0] nsum;
  logic              sum_ok, true_carry, res_zero;

  assign wsum = {1'b0, a_i} + {1'b0, b_i};
  assign nsum = {1'b0, a_i[NARROW_W-1:0]} + {1'b0, b_i[NARROW_W-1:0]};
  assign sum_ok = wide_i ? (wsum[DATA_W-1:0] == r_i)
                         : (nsum[NARROW_W-1:0] == r_i[NARROW_W-1:0]);
  assign true_carry = wide_i ? wsum[DATA_W] : nsum[NARROW_W];
  assign res_zero = wide_i ? (r_i == '0) : ((r_i & NMASK) == '0);

  always_comb begin
    assert_upper_kept_R1: assert (ccr_o[7:4] == ccr_i[7:4])
      else $error("upper ccr bits changed");
    if (op_i == 3'd0 || op_i > 3'd4)
      assert_idle_R2: assert (ccr_o == ccr_i) else $error("idle op changed ccr");
    if (op_i >= 3'd1 && op_i <= 3'd4)
      assert_zero_flag_R4: assert (ccr_o[2] == res_zero) else $error("Z wrong");
    if (op_i == 3'd1 && sum_ok)
      assert_add_carry_R5: assert (ccr_o[0] == true_carry) else $error("add C wrong");
    if (op_i == 3'd3)
      assert_shift_ovf_R9: assert (ccr_o[1] == (ccr_o[3] ^ ccr_o[0]) && ccr_o[0] == shift_c_i)
        else $error("shift V/C wrong");
    if (op_i == 3'd4)
      assert_test_flags_R10: assert (!ccr_o[1] && ccr_o[0] == ccr_i[0])
        else $error("test V/C wrong");
  end
endmodule

bind ccr_flag_gen ccr_flag_gen_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) chk_i (
  .op_i(op_i), .wide_i(wide_i), .a_i(a_i), .b_i(b_i), .r_i(r_i),
  .shift_c_i(shift_c_i), .ccr_i(ccr_i), .ccr_o(ccr_o)
);

// File: tb/ccr_flag_gen_tb.sv
module ccr_flag_gen_tb_top;
  logic        clk = 1'b0;
  logic [2:0]  op_i;
  logic        wide_i;
  logic [15:0] a_i, b_i, r_i;
  logic        shift_c_i;
  logic [7:0]  ccr_i;
  logic [7:0]  ccr_o;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ccr_flag_gen dut_i (
    .op_i(op_i), .wide_i(wide_i), .a_i(a_i), .b_i(b_i), .r_i(r_i),
    .shift_c_i(shift_c_i), .ccr_i(ccr_i), .ccr_o(ccr_o)
  );

  function automatic logic [7:0] model(input logic [2:0] op, input logic w,
      input logic [15:0] a, input logic [15:0] b, input logic [15:0] r,
      input logic sc, input logic [7:0] c);
    logic [7:0] m;
    int top;
    logic pa, pb, pr, zr;
    top = w ? 15 : 7;
    pa = a[top]; pb = b[top]; pr = r[top];
    zr = w ? (r == 16'h0) : (r[7:0] == 8'h0);
    m = c;
    if (op >= 3'd1 && op <= 3'd4) begin
      m[3] = pr;
      m[2] = zr;
    end
    case (op)
      3'd1: begin
        m[0] = (int'(pa) + int'(pb) + int'(!pr)) >= 2;
        m[1] = (pa == pb) && (pr != pa);
      end
      3'd2: begin
        m[0] = (int'(!pa) + int'(pb) + int'(pr)) >= 2;
        m[1] = (pa != pb) && (pr != pa);
      end
      3'd3: begin
        m[0] = sc;
        m[1] = (pr != sc);
      end
      3'd4: m[1] = 1'b0;
      default: ;
    endcase
    return m;
  endfunction

  task automatic apply(input logic [2:0] op, input logic w, input logic [15:0] a,
      input logic [15:0] b, input logic [15:0] r, input logic sc,
      input logic [7:0] c, input string req);
    logic [7:0] exp;
    @(posedge clk);
    op_i = op; wide_i = w; a_i = a; b_i = b; r_i = r; shift_c_i = sc; ccr_i = c;
    exp = model(op, w, a, b, r, sc, c);
    @(negedge clk);
    checks++;
    if (ccr_o !== exp) begin
      errors++;
      $display("FAIL %s op=%0d w=%0d a=%h b=%h r=%h sc=%0d ccr=%h: actual %h expected %h",
               req, op, w, a, b, r, sc, c, ccr_o, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED1234);
    op_i = 0; wide_i = 0; a_i = 0; b_i = 0; r_i = 0; shift_c_i = 0; ccr_i = 0;
    repeat (2) @(posedge clk);
    // reset-like idle state: no update with zero inputs
    apply(3'd0, 0, 16'h0, 16'h0, 16'h0, 0, 8'h00, "R2 idle");
    // R1/R2: unused codes pass through, upper bits kept
    apply(3'd5, 1, 16'h0000, 16'h0, 16'h0, 1, 8'hA5, "R2 code5");
    apply(3'd7, 0, 16'hFFFF, 16'h1, 16'h0, 0, 8'h5A, "R2 code7");
    apply(3'd1, 0, 16'h0080, 16'h0080, 16'h0000, 0, 8'hF0, "R1 upper kept");
    // R5/R6 byte add corners
    apply(3'd1, 0, 16'h007F, 16'h0001, 16'h0080, 0, 8'h00, "R6 add ovf");
    apply(3'd1, 0, 16'h00FF, 16'h0001, 16'h0000, 0, 8'h00, "R5 add carry");
    // R7/R8 sub corners
    apply(3'd2, 0, 16'h0000, 16'h0001, 16'h00FF, 0, 8'h00, "R7 borrow");
    apply(3'd2, 0, 16'h0080, 16'h0001, 16'h007F, 0, 8'h00, "R8 sub ovf");
    apply(3'd2, 1, 16'h8000, 16'h0001, 16'h7FFF, 0, 8'h0F, "R8 wide sub ovf");
    // R3: junk in upper byte is ignored in byte mode
    apply(3'd4, 0, 16'h0, 16'h0, 16'hFF00, 0, 8'h03, "R3 narrow zero");
    apply(3'd4, 1, 16'h0, 16'h0, 16'hFF00, 0, 8'h03, "R3 wide sign");
    apply(3'd1, 1, 16'hFFFF, 16'h0001, 16'h0000, 0, 8'h00, "R5 wide carry");
    // R4 N/Z
    apply(3'd4, 1, 16'h0, 16'h0, 16'h0000, 0, 8'h0A, "R4 zero");
    // R9 shift
    apply(3'd3, 0, 16'h0, 16'h0, 16'h0080, 1, 8'h00, "R9 shift N=1 C=1");
    apply(3'd3, 0, 16'h0, 16'h0, 16'h0040, 1, 8'h00, "R9 shift N=0 C=1");
    // R10 test keeps C, clears V
    apply(3'd4, 0, 16'h0, 16'h0, 16'h0012, 0, 8'h03, "R10 test");
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      logic w;
      logic [15:0] a, b, r;
      op = 3'($urandom_range(0, 7));
      w = 1'($urandom);
      a = 16'($urandom); b = 16'($urandom);
      case ($urandom_range(0, 2))
        0: r = a + b;
        1: r = a - b;
        default: r = 16'($urandom);
      endcase
      apply(op, w, a, b, r, 1'($urandom), 8'($urandom), "R4 R5 R6 R7 R8 R9 R10 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule